// File: doc/BRIEF.md
# Bus Ownership Acquisition Unit

This unit sits inside a bus master on a shared, handshaked expansion bus. Local logic says when it wants the bus; the unit drives the active-low request line to the backplane arbiter and watches the active-low grant line. It declares local ownership only once the grant is present and no transfer is on the bus, which it judges from the start and end handshake strobes. The strobes, like the grant, arrive without any timing relation to the local clock and pass through synchronizers first.

Ownership changes only at cycle boundaries. A grant that appears while a transfer runs takes effect when that transfer finishes. A grant that is withdrawn before that point leaves the unit without the bus until the grant returns. Release is governed by the grant alone. While the grant stays asserted the unit keeps the bus even after its own request has dropped. Once the grant goes away, the unit lets go as soon as the bus is between transfers. The ownership flag also serves as the tri-state enable for the master's bus drivers. While the unit owns an idle bus and the master has nothing queued, it pulses a request for a harmless dummy read at a fixed interval, so the shared lines do not float.

Top module: `bus_own_unit`

## Requirements
- R1: During and straight after reset, busReqN is 1, ownBus is 0, drvEn is 0 and dummyRd is 0.
- R2: busReqN is the inverse of wantBus as registered on the previous clock edge, whatever the grant or ownership state.
- R3: When wantBus is held, the unit is waiting for a grant, and startN and endN are both high (no transfer), a grant (grantN driven to 0) makes ownBus rise on the fourth clock edge after the change.
- R4: A grant that arrives while a transfer is in progress (startN or endN low) does not give ownership. ownBus rises on the third clock edge after startN and endN are both back high.
- R5: If the grant is withdrawn (grantN back to 1) before ownership is taken, the unit does not take ownership when the transfer ends. It takes ownership only after grantN returns to 0, four edges after that change.
- R6: While owning an idle bus, driving grantN to 1 makes ownBus fall on the fourth clock edge after the change, whether or not wantBus is still high.
- R7: When the grant is withdrawn during a transfer, ownBus stays high until startN and endN are both high again, then falls on the third clock edge after that.
- R8: While the grant stays asserted, ownBus stays high even after wantBus drops.
- R9: drvEn always equals ownBus, so the bus drivers are in high impedance whenever the unit is not the owner.
- R10: While the unit owns the bus, the bus is idle and xferPending is 0, dummyRd is a one-cycle pulse repeating every DUMMY_GAP (default 8) cycles. The first pulse appears DUMMY_GAP-1 edges after ownership starts.
- R11: No dummyRd pulse occurs while xferPending is 1, or while startN or endN is low.
- R12: If wantBus drops before the grant arrives, a later grant alone does not give ownership.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low synchronous reset |
| wantBus | input | 1 | Local logic wants the bus (active high, local clock domain) |
| xferPending | input | 1 | Master has a real transfer queued (suppresses dummy reads) |
| grantN | input | 1 | Arbiter grant, active low, asynchronous |
| startN | input | 1 | Bus transfer start strobe, active low, asynchronous |
| endN | input | 1 | Bus transfer acknowledge strobe, active low, asynchronous |
| busReqN | output | 1 | Bus request to the arbiter, active low |
| ownBus | output | 1 | The unit owns the bus |
| drvEn | output | 1 | Tri-state enable for the master's bus drivers |
| dummyRd | output | 1 | One-cycle request for an idempotent dummy read |

## Verification
Every bus-side input passes through two synchronizer stages, so the bench counts edges exactly. A grant change reaches ownBus on the fourth edge when the bus is quiet, since the state machine first notes the grant and then takes the bus. The end of a transfer reaches ownBus on the third edge, and a request change reaches busReqN on the first. The bench drives inputs on falling clock edges and samples on falling edges. It checks that an output still holds its old value one edge before it is due and has its new value on the due edge, so a result that comes early or late is reported. Dummy-read pulses are checked on the exact edges where they are due, and their absence is checked over long windows in which a pulse would otherwise have appeared.

// File: rtl/busown_pkg.sv
package busown_pkg;

  // Ownership state machine encoding
  typedef enum logic [2:0] {
    S_IDLE       = 3'd0,
    S_WAIT_GRANT = 3'd1,
    S_WAIT_CYCLE = 3'd2,
    S_OWNED      = 3'd3,
    S_RELEASING  = 3'd4
  } own_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic dummyArm;   // owner with the bus settled: dummy reads allowed
  } ctl_strobe_t;

  // Synchronized bus view from datapath to control
  typedef struct packed {
    logic grantSeen;  // grant asserted after synchronization
    logic boundary;   // both handshake strobes negated: between transfers
  } bus_stat_t;

endpackage

// File: rtl/busown_datapath.sv
module busown_datapath
  import busown_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DUMMY_GAP   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wantBus,
  input  logic        xferPending,
  input  logic        grantN,
  input  logic        startN,
  input  logic        endN,
  input  ctl_strobe_t ctl,
  output bus_stat_t   stat,
  output logic        busReqN,
  output logic        dummyRd
);

  localparam int NUM_ASYNC = 3;
  localparam int CNT_W     = (DUMMY_GAP > 2) ? $clog2(DUMMY_GAP) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DUMMY_GAP - 1);

  // Synchronizer chain for the asynchronous bus inputs
  logic [NUM_ASYNC-1:0] rawIn;
  logic [NUM_ASYNC-1:0] syncStage [SYNC_STAGES];
  logic [NUM_ASYNC-1:0] syncOut;

  assign rawIn = {grantN, startN, endN};

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncStage[g] <= '1;
          else       syncStage[g] <= rawIn;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) syncStage[g] <= '1;
          else       syncStage[g] <= syncStage[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = syncStage[SYNC_STAGES-1];

  always_comb begin
    stat.grantSeen = !syncOut[2];
    stat.boundary  = syncOut[1] & syncOut[0];
  end

  // Request line: registered copy of the local wish
  always_ff @(posedge clk) begin
    if (!rstN) busReqN <= 1'b1;
    else       busReqN <= !wantBus;
  end

  // Dummy read interval counter
  logic             dummyEligible;
  logic [CNT_W-1:0] gapCnt;

  assign dummyEligible = ctl.dummyArm && stat.boundary && !xferPending;

  always_ff @(posedge clk) begin
    if (!rstN)                  gapCnt <= '0;
    else if (!dummyEligible)    gapCnt <= '0;
    else if (gapCnt == CNT_LAST) gapCnt <= '0;
    else                        gapCnt <= gapCnt + 1'b1;
  end

  assign dummyRd = dummyEligible && (gapCnt == CNT_LAST);

  // R2: a new local wish shows on the request line one edge later
  a_r2_req_follows: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wantBus) |=> !busReqN);

  // R10: a dummy pulse lasts a single cycle
  a_r10_dummy_single: assert property (@(posedge clk) disable iff (!rstN)
    dummyRd |=> !dummyRd);

  // R11: no dummy read while a real transfer is queued or the bus is busy
  a_r11_dummy_quiet: assert property (@(posedge clk) disable iff (!rstN)
    dummyRd |-> (!xferPending && startN !== 1'bx && stat.boundary));

endmodule

// File: rtl/busown_control.sv
module busown_control
  import busown_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wantBus,
  input  bus_stat_t   stat,
  output ctl_strobe_t ctl,
  output logic        ownBus
);

  own_state_e state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (wantBus) nextState = S_WAIT_GRANT;
      end
      S_WAIT_GRANT: begin
        if (!wantBus)           nextState = S_IDLE;
        else if (stat.grantSeen) nextState = S_WAIT_CYCLE;
      end
      S_WAIT_CYCLE: begin
        if (!wantBus)            nextState = S_IDLE;
        else if (!stat.grantSeen) nextState = S_WAIT_GRANT;
        else if (stat.boundary)  nextState = S_OWNED;
      end
      S_OWNED: begin
        if (!stat.grantSeen) nextState = S_RELEASING;
      end
      S_RELEASING: begin
        if (stat.grantSeen)     nextState = S_OWNED;
        else if (stat.boundary) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign ownBus       = (state == S_OWNED) || (state == S_RELEASING);
  assign ctl.dummyArm = (state == S_OWNED);

  // R3, R4: ownership is taken only with the grant present at a cycle boundary
  a_r3_take_needs_grant: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ownBus) |-> $past(stat.grantSeen && stat.boundary));

  // R6, R7: ownership is dropped only without the grant, between transfers
  a_r7_release_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ownBus) |-> $past(!stat.grantSeen && stat.boundary));

  // R8: an owner keeps the bus while the grant is held
  a_r8_keep_while_granted: assert property (@(posedge clk) disable iff (!rstN)
    (ownBus && stat.grantSeen) |=> ownBus);

  // R12: without a pending wish, ownership cannot appear on the next edge
  a_r12_no_take_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |=> !ownBus);

endmodule

// File: rtl/bus_own_unit.sv
module bus_own_unit
  import busown_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DUMMY_GAP   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic wantBus,
  input  logic xferPending,
  input  logic grantN,
  input  logic startN,
  input  logic endN,
  output logic busReqN,
  output logic ownBus,
  output logic drvEn,
  output logic dummyRd
);

  ctl_strobe_t ctl;
  bus_stat_t   stat;

  busown_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .DUMMY_GAP  (DUMMY_GAP)
  ) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .wantBus    (wantBus),
    .xferPending(xferPending),
    .grantN     (grantN),
    .startN     (startN),
    .endN       (endN),
    .ctl        (ctl),
    .stat       (stat),
    .busReqN    (busReqN),
    .dummyRd    (dummyRd)
  );

  busown_control control_i (
    .clk   (clk),
    .rstN  (rstN),
    .wantBus(wantBus),
    .stat  (stat),
    .ctl   (ctl),
    .ownBus(ownBus)
  );

  // R9: drivers are enabled exactly while the bus is owned
  assign drvEn = ownBus;

  // R10: dummy reads come only from an owner
  a_r10_dummy_owner: assert property (@(posedge clk) disable iff (!rstN)
    dummyRd |-> drvEn);

endmodule

// File: tb/bus_own_unit_tb_top.sv
module bus_own_unit_tb_top;

  logic clk = 1'b0;
  logic rstN, wantBus, xferPending, grantN, startN, endN;
  logic busReqN, ownBus, drvEn, dummyRd;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_own_unit dut_i (
    .clk(clk), .rstN(rstN), .wantBus(wantBus), .xferPending(xferPending),
    .grantN(grantN), .startN(startN), .endN(endN),
    .busReqN(busReqN), .ownBus(ownBus), .drvEn(drvEn), .dummyRd(dummyRd)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic chkOwn(input string req, input logic exp);
    chk(ownBus === exp, req, int'(ownBus), int'(exp));
    chk(drvEn === ownBus, "R9", int'(drvEn), int'(ownBus));
  endtask

  task automatic doReset();
    rstN = 1'b0; wantBus = 1'b0; xferPending = 1'b0;
    grantN = 1'b1; startN = 1'b1; endN = 1'b1;
    tick(3);
    rstN = 1'b1;
    tick(1);
  endtask

  // Get to owner state from reset on a quiet bus
  task automatic becomeOwner();
    wantBus = 1'b1; tick(1);
    grantN = 1'b0;  tick(4);
  endtask

  task automatic tResetState();
    doReset();
    chk(busReqN === 1'b1, "R1", int'(busReqN), 1);
    chk(ownBus === 1'b0, "R1", int'(ownBus), 0);
    chk(drvEn === 1'b0, "R1", int'(drvEn), 0);
    chk(dummyRd === 1'b0, "R1", int'(dummyRd), 0);
  endtask

  task automatic tAcquireQuiet();
    doReset();
    wantBus = 1'b1; tick(1);
    chk(busReqN === 1'b0, "R2", int'(busReqN), 0);
    grantN = 1'b0;
    tick(3); chkOwn("R3", 1'b0);
    tick(1); chkOwn("R3", 1'b1);
  endtask

  task automatic tAcquireBusy();
    doReset();
    startN = 1'b0; endN = 1'b0;
    wantBus = 1'b1; tick(4);
    grantN = 1'b0; tick(6); chkOwn("R4", 1'b0);
    startN = 1'b1; endN = 1'b1;
    tick(2); chkOwn("R4", 1'b0);
    tick(1); chkOwn("R4", 1'b1);
  endtask

  task automatic tGrantWithdrawn();
    doReset();
    startN = 1'b0; endN = 1'b0;
    wantBus = 1'b1; tick(4);
    grantN = 1'b0; tick(4);
    grantN = 1'b1; tick(4);
    startN = 1'b1; endN = 1'b1;
    tick(10); chkOwn("R5", 1'b0);
    grantN = 1'b0;
    tick(3); chkOwn("R5", 1'b0);
    tick(1); chkOwn("R5", 1'b1);
  endtask

  task automatic tReleaseQuiet();
    doReset();
    becomeOwner();
    chkOwn("R6", 1'b1);
    grantN = 1'b1;
    tick(3); chkOwn("R6", 1'b1);
    tick(1); chkOwn("R6", 1'b0);
  endtask

  task automatic tReleaseBusy();
    doReset();
    becomeOwner();
    wantBus = 1'b0;
    startN = 1'b0; endN = 1'b0; tick(4);
    grantN = 1'b1; tick(6); chkOwn("R7", 1'b1);
    startN = 1'b1; endN = 1'b1;
    tick(2); chkOwn("R7", 1'b1);
    tick(1); chkOwn("R7", 1'b0);
  endtask

  task automatic tKeepAfterReqDrop();
    doReset();
    becomeOwner();
    wantBus = 1'b0; tick(1);
    chk(busReqN === 1'b1, "R2", int'(busReqN), 1);
    tick(12); chkOwn("R8", 1'b1);
  endtask

  task automatic tDummyPulses();
    doReset();
    becomeOwner();
    chkOwn("R10", 1'b1);
    tick(6); chk(dummyRd === 1'b0, "R10", int'(dummyRd), 0);
    tick(1); chk(dummyRd === 1'b1, "R10", int'(dummyRd), 1);
    tick(1); chk(dummyRd === 1'b0, "R10", int'(dummyRd), 0);
    tick(6); chk(dummyRd === 1'b0, "R10", int'(dummyRd), 0);
    tick(1); chk(dummyRd === 1'b1, "R10", int'(dummyRd), 1);
  endtask

  task automatic tNoDummy();
    int pulses;
    doReset();
    becomeOwner();
    xferPending = 1'b1;
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (dummyRd === 1'b1) pulses++;
    end
    chk(pulses == 0, "R11", pulses, 0);
    startN = 1'b0;
    tick(1);
    xferPending = 1'b0;
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (dummyRd === 1'b1) pulses++;
    end
    chk(pulses == 0, "R11", pulses, 0);
    chkOwn("R11", 1'b1);
  endtask

  task automatic tReqDropBeforeGrant();
    doReset();
    wantBus = 1'b1; tick(2);
    wantBus = 1'b0; tick(2);
    grantN = 1'b0; tick(10);
    chkOwn("R12", 1'b0);
    chk(busReqN === 1'b1, "R12", int'(busReqN), 1);
  endtask

  initial begin
    tResetState();
    tAcquireQuiet();
    tAcquireBusy();
    tGrantWithdrawn();
    tReleaseQuiet();
    tReleaseBusy();
    tKeepAfterReqDrop();
    tDummyPulses();
    tNoDummy();
    tReqDropBeforeGrant();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule